// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped master for the two-wire PHY management bus. Software places a complete pre-encoded 32-bit management frame in the command register. The block then sends a run of preamble ones and shifts the frame out on the management clock and data pins. The clock rate comes from a programmable divisor. The data pin changes while the management clock is low and is sampled on its rising edge.

For a read frame, the block releases the data pin from the turnaround bits onward. It collects the sixteen bits the PHY returns into the low half of the command register. At the end of every frame a sticky completion flag is set, and software clears it by writing a one.

Frames start only while the enable bit in the control register is set. While a frame is in progress the command register refuses new writes, and a busy flag shows this. A driver polls the completion flag a bounded number of times and treats a timeout as a failed access.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, every register reads zero, `mdc` is low and `mdio_oe` is low.
- R2: The command word at address 0 is sent MSB first and uses these fields: bits 31:30 start (01), bits 29:28 opcode (10 = read, 01 = write), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround, bits 15:0 data. A write frame drives all 32 bits.
- R3: Each frame begins with 32 one bits of preamble, driven with `mdio_oe` high, so one frame lasts 64 MDC periods.
- R4: When a read frame completes, bits 15:0 of the command register hold the 16 bits sampled on the rising edges of the last 16 MDC periods, first bit in bit 15. Bits 31:16 keep the command.
- R5: During a read frame `mdio_oe` is low for the last 18 bit times (turnaround and data) and high for the 46 bit times before them.
- R6: Event register (address 2) bit 0 is set when a frame completes and stays set until a write with bit 0 = 1 to address 2. A write with bit 0 = 0 leaves it unchanged.
- R7: The MDC high and low phases each last DIV+1 clock cycles. DIV is the value of the divisor register (address 1) captured when the frame starts. MDC is low when no frame is running.
- R8: Control register (address 3) bit 0 enables the engine. A command write while it is 0 stores the word but starts no frame.
- R9: Event register bit 1 reads 1 while a frame is in progress. A command-register write during a frame is ignored and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable (high = drive) |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit position or a wrong shift count in the engine shows up within one frame. The captured pin stream no longer matches the expected preamble and command, the released window is misplaced, or the read data lands shifted in the command register. A divider fault changes the number of clock cycles that MDC spends high, which the bench counts exactly, per frame. Faults in the event flag, busy gating or enable gating appear at the register port on the first poll after the stimulus. A second, unwanted frame is visible as extra MDC edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    REG_CMD = 2'd0,
    REG_DIV = 2'd1,
    REG_EVT = 2'd2,
    REG_CTL = 2'd3
  } mdio_reg_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam int CMD_W = 32;
  localparam int DATA_BITS = 16;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  logic             edge_now;

  assign edge_now = run && (cnt_q == half_q);
  assign rise     = edge_now && !mdc;
  assign fall     = edge_now && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '0;
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= div_val;
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      if (edge_now) begin
        cnt_q <= '0;
        mdc   <= ~mdc;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end
  end

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= half_q));
  assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> !mdc);
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CMD_W-1:0]     cmd,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_BITS-1:0] rx_data
);
  localparam int FRAME_BITS = PRE_LEN + CMD_W;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] TA_POS   = POS_W'(PRE_LEN + 14);
  localparam logic [POS_W-1:0] DATA_POS = POS_W'(PRE_LEN + 16);

  logic [FRAME_BITS-1:0] sh_q;
  logic [FRAME_BITS-1:0] sh_load;
  logic [POS_W-1:0]      pos_q;
  logic [POS_W-1:0]      pos_nx;
  logic                  rd_q;

  assign sh_load = {{PRE_LEN{1'b1}}, cmd};
  assign pos_nx  = pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      pos_q   <= '0;
      rd_q    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh_q    <= sh_load;
        pos_q   <= '0;
        rd_q    <= (cmd[29:28] == OP_READ);
        busy    <= 1'b1;
        mdio_o  <= sh_load[FRAME_BITS-1];
        mdio_oe <= 1'b1;
        rx_data <= '0;
      end else if (busy) begin
        if (rise && rd_q && (pos_q >= DATA_POS)) begin
          rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
        end
        if (fall) begin
          if (pos_q == LAST_POS) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            pos_q   <= pos_nx;
            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            mdio_o  <= sh_q[FRAME_BITS-2];
            mdio_oe <= !(rd_q && (pos_nx >= TA_POS));
          end
        end
      end
    end
  end

  assert_released_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (pos_q >= TA_POS)) |-> !mdio_oe);
  assert_driven_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q) |-> mdio_oe);
  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CMD_W-1:0]     wr_data,
  input  logic [1:0]           rd_addr,
  output logic [CMD_W-1:0]     rd_data,
  input  logic                 busy,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] rx_data,
  output logic                 start,
  output logic [CMD_W-1:0]     cmd_q,
  output logic [DIV_W-1:0]     div_q
);
  logic en_q;
  logic evt_q;
  logic wr_cmd;
  logic evt_clr;

  assign wr_cmd  = wr_en && (wr_addr == REG_CMD) && !busy;
  assign start   = wr_cmd && en_q;
  assign evt_clr = wr_en && (wr_addr == REG_EVT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      div_q <= '0;
      en_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        cmd_q <= wr_data;
      end else if (done && (cmd_q[29:28] == OP_READ)) begin
        cmd_q[DATA_BITS-1:0] <= rx_data;
      end
      if (wr_en && (wr_addr == REG_DIV)) div_q <= wr_data[DIV_W-1:0];
      if (wr_en && (wr_addr == REG_CTL)) en_q  <= wr_data[0];
      if (done)         evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_CMD: rd_data <= cmd_q;
        REG_DIV: rd_data <= {{(CMD_W-DIV_W){1'b0}}, div_q};
        REG_EVT: rd_data <= {{(CMD_W-2){1'b0}}, busy, evt_q};
        default: rd_data <= {{(CMD_W-1){1'b0}}, en_q};
      endcase
    end
  end

  assert_event_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !evt_clr) |=> evt_q);
  assert_cmd_frozen_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && (wr_addr == REG_CMD)) |=> (cmd_q == $past(cmd_q)));
  assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !start);
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 start;
  logic                 busy;
  logic                 done;
  logic                 rise;
  logic                 fall;
  logic [CMD_W-1:0]     cmd_q;
  logic [DIV_W-1:0]     div_q;
  logic [DATA_BITS-1:0] rx_data;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .rx_data(rx_data), .start(start), .cmd_q(cmd_q), .div_q(div_q)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .start(start), .run(busy), .div_val(div_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shift_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start), .cmd(wr_data), .rise(rise),
    .fall(fall), .mdio_i(mdio_i), .busy(busy), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rx_data(rx_data)
  );

  assert_edges_only_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |-> busy);
endmodule

// File: tb/mdio_mgmt_bench.sv
module mdio_mgmt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt u_mdio_mgmt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and pin observers
  int fcnt = 0, rcnt = 0, hcnt = 0;
  int fbase = 0, rbase = 0, hbase = 0;
  logic [15:0] resp = '0;
  logic cap_o [64];
  logic cap_oe[64];

  always @(negedge mdc) begin
    fcnt = fcnt + 1;
    if ((fcnt - fbase) >= 48 && (fcnt - fbase) <= 63) mdio_i = resp[63 - (fcnt - fbase)];
    else mdio_i = 1'b1;
  end

  always @(posedge mdc) begin
    if ((rcnt - rbase) >= 0 && (rcnt - rbase) < 64) begin
      cap_o[rcnt - rbase]  = mdio_o;
      cap_oe[rcnt - rbase] = mdio_oe;
    end
    rcnt = rcnt + 1;
  end

  always @(posedge clk) if (mdc) hcnt = hcnt + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic [31:0] make_cmd(input bit is_rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] dat);
    logic [31:0] c;
    c = is_rd ? 32'h6002_0000 : 32'h5002_0000;
    c = c | ({27'd0, phy} << 23) | ({27'd0, rg} << 18);
    if (!is_rd) c = c | {16'd0, dat};
    return c;
  endfunction

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  // Run one frame and check pin stream, timing, event and read data.
  task automatic frame(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] dat, input logic [7:0] dv);
    logic [31:0] c, v, po, poe, pre;
    bit ok;
    c = make_cmd(is_rd, phy, rg, dat);
    resp = dat;
    wr(2'd1, {24'd0, dv});
    fbase = fcnt; rbase = rcnt; hbase = hcnt;
    wr(2'd0, c);
    wait_done(ok);
    check("R6 completion seen", {31'd0, ok}, 32'd1);
    pre = '0; po = '0; poe = '0;
    for (int k = 0; k < 32; k++) begin
      pre[31-k] = cap_o[k] & cap_oe[k];
      po[31-k]  = cap_o[32+k];
      poe[31-k] = cap_oe[32+k];
    end
    check("R3 preamble ones", pre, 32'hFFFF_FFFF);
    check("R7 mdc high cycles", hcnt - hbase, 64 * (dv + 1));
    check("R3 64 mdc periods", rcnt - rbase, 32'd64);
    if (is_rd) begin
      check("R2 read header bits", {18'd0, po[31:18]}, {18'd0, c[31:18]});
      check("R5 release window", poe, 32'hFFFC_0000);
      rd(2'd0, v);
      check("R4 read data in cmd reg", v, {c[31:16], dat});
    end else begin
      check("R2 write frame bits", po, c);
      check("R2 write drives all", poe, 32'hFFFF_FFFF);
      rd(2'd0, v);
      check("R4 cmd reg kept on write", v, c);
    end
    check("R1 mdio released idle", {31'd0, mdio_oe}, 32'd0);
    check("R7 mdc low idle", {31'd0, mdc}, 32'd0);
    rd(2'd2, v);
    check("R6 event set, not busy", v, 32'd1);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    check("R6 event cleared", v, 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    bit ok;
    int r0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reset reg", v, 32'd0);
    end
    check("R1 mdc low", {31'd0, mdc}, 32'd0);
    check("R1 mdio_oe low", {31'd0, mdio_oe}, 32'd0);

    // R8 disabled: command stored, no frame
    r0 = rcnt;
    c = make_cmd(0, 5'd3, 5'd4, 16'hABCD);
    wr(2'd0, c);
    repeat (300) @(negedge clk);
    check("R8 no mdc edges when disabled", rcnt - r0, 32'd0);
    rd(2'd2, v);
    check("R8 no event when disabled", v, 32'd0);
    rd(2'd0, v);
    check("R8 word stored", v, c);

    wr(2'd3, 32'd1);
    frame(0, 5'd1, 5'd2, 16'h1234, 8'd0);
    frame(1, 5'd31, 5'd17, 16'hC35A, 8'd2);
    frame(1, 5'd0, 5'd0, 16'hFFFF, 8'd1);
    frame(0, 5'd31, 5'd31, 16'h0000, 8'd0);

    // R6 write of zero leaves event set
    wr(2'd1, 32'd0);
    wr(2'd0, make_cmd(0, 5'd5, 5'd6, 16'h0F0F));
    wait_done(ok);
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    check("R6 write zero keeps event", v, 32'd1);
    wr(2'd2, 32'd1);

    // R9 busy flag and ignored command write
    wr(2'd1, 32'd3);
    r0 = rcnt;
    c = make_cmd(0, 5'd9, 5'd10, 16'h5555);
    wr(2'd0, c);
    rd(2'd2, v);
    check("R9 busy visible", v, 32'd2);
    wr(2'd0, make_cmd(1, 5'd1, 5'd1, 16'd0));
    wait_done(ok);
    repeat (1200) @(negedge clk);
    check("R9 only one frame", rcnt - r0, 32'd64);
    rd(2'd0, v);
    check("R9 write during busy ignored", v, c);
    wr(2'd2, 32'd1);

    // Random frames
    for (int n = 0; n < 10; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      frame(rv[0], rv[5:1], rv[10:6], rv[26:11], {6'd0, rv[28:27]});
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule